// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits in front of a flash controller and watches a stream of single-cycle bus writes, each an address offset with a data word. It recognizes the unlock-style multi-write command sequences used to drive a flash array. For every sequence it completes, it issues exactly one operation request carrying an operation code and, where one applies, the sector or page address. The operations are: erase a logical sector, erase a physical sector, enter page mode, load a page word, program a page, and clear status.

Page-word loads are single writes to a fixed offset. They bypass the unlock state machine and fill a page assembly buffer through a pointer that advances by itself. Commands that take array time raise a BUSY flag. BUSY is held by an internal responder that reports completion after a fixed, per-operation number of cycles. While BUSY is high, the decoder accepts nothing.

Top module: `flash_cmd_seq_dec`

## Requirements
- R1: After reset, `req_valid` is 0, `busy` is 0 and `page_ptr` is 0.
- R2: The six writes 5554h/AAh, AAA8h/55h, 5554h/80h, 5554h/AAh, AAA8h/55h and then X/30h issue one request with `req_op`=1 (erase logical sector) and `req_addr`=X. The request appears in the cycle after the last write. Only data bits [7:0] are compared.
- R3: The same first five writes followed by X/40h issue `req_op`=2 (erase physical sector) with `req_addr`=X.
- R4: The writes 5554h/AAh, AAA8h/55h, 5554h/A0h and then X/AAh issue `req_op`=5 (program page) with `req_addr`=X.
- R5: A write of 50h to 5554h from idle issues `req_op`=3 (enter page mode) and returns `page_ptr` to 0.
- R6: A write of F5h to 5554h from idle issues `req_op`=6 (clear status).
- R7: Any write to 55F0h issues `req_op`=4 (load page word). It stores the full 32-bit data at `page_ptr` and advances `page_ptr` by one. After the last of the 64 words (a 256-byte page), the pointer wraps to 0. It never sets `busy`.
- R8: A load-page-word write arriving in the middle of a partly matched sequence leaves that sequence's progress intact.
- R9: A write that does not match the next expected step of a partly matched sequence returns the decoder to idle and issues no request. That write does not itself count as a first step.
- R10: Erase requests hold `busy` high for 8 cycles, program page for 5 cycles and clear status for 2 cycles. `busy` rises in the same cycle as the request. Enter page and load word leave `busy` low.
- R11: While `busy` is high, writes are ignored: no request is issued, and neither the page buffer nor `page_ptr` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write cycle strobe, one write per high cycle |
| wr_addr | input | 16 | Write address offset |
| wr_data | input | 32 | Write data |
| rd_idx | input | 6 | Page buffer word index for readout |
| req_valid | output | 1 | One-cycle operation request strobe |
| req_op | output | 3 | Operation code of the request |
| req_addr | output | 16 | Sector or page address of the last request |
| busy | output | 1 | Array operation in progress |
| page_ptr | output | 6 | Next page buffer word to be loaded |
| rd_word | output | 32 | Page buffer word at `rd_idx` |

## Verification
The assertions take for granted that the bus presents at most one write per cycle, with address and data stable across the sampling edge. They also assume that the array latencies are at least one cycle, so a busy interval always ends through a zero count. The stimulus drives every write on the falling edge, drops `wr_en` between writes, and only ever runs the default latencies. Writes during BUSY are issued on purpose, because their rejection is exactly what the busy-gating properties state.

// File: rtl/fcsd_pkg.sv
package fcsd_pkg;

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_ERASE_LOG  = 3'd1,
    OP_ERASE_PHYS = 3'd2,
    OP_ENTER_PAGE = 3'd3,
    OP_LOAD_WORD  = 3'd4,
    OP_PROGRAM    = 3'd5,
    OP_CLEAR      = 3'd6
  } op_e;

  localparam logic [15:0] ADR_KEY_A = 16'h5554;
  localparam logic [15:0] ADR_KEY_B = 16'hAAA8;
  localparam logic [15:0] ADR_LOAD  = 16'h55F0;

  localparam logic [7:0] D_KEY1     = 8'hAA;
  localparam logic [7:0] D_KEY2     = 8'h55;
  localparam logic [7:0] D_ERASE    = 8'h80;
  localparam logic [7:0] D_PROG     = 8'hA0;
  localparam logic [7:0] D_SEC_LOG  = 8'h30;
  localparam logic [7:0] D_SEC_PHYS = 8'h40;
  localparam logic [7:0] D_PAGE     = 8'h50;
  localparam logic [7:0] D_CLEAR    = 8'hF5;

  function automatic logic op_takes_time(op_e op);
    return (op == OP_ERASE_LOG) || (op == OP_ERASE_PHYS) ||
           (op == OP_PROGRAM)   || (op == OP_CLEAR);
  endfunction

endpackage

// File: rtl/fcsd_seq_match.sv
module fcsd_seq_match
  import fcsd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_byte,
  input  logic              hold,
  output logic              fire,
  output op_e               fire_op,
  output logic              req_valid,
  output op_e               req_op,
  output logic [ADDR_W-1:0] req_addr
);

  typedef enum logic [2:0] {
    S_IDLE, S_U1, S_U2, S_E3, S_E4, S_E5, S_P3
  } st_e;

  st_e state_q, state_d;
  logic accept, at_a, at_b, at_load;

  assign accept  = wr_en && !hold;
  assign at_a    = (wr_addr == ADDR_W'(ADR_KEY_A));
  assign at_b    = (wr_addr == ADDR_W'(ADR_KEY_B));
  assign at_load = (wr_addr == ADDR_W'(ADR_LOAD));

  always_comb begin
    state_d = state_q;
    fire    = 1'b0;
    fire_op = OP_NONE;
    if (accept) begin
      if (at_load) begin
        fire    = 1'b1;
        fire_op = OP_LOAD_WORD;
      end else begin
        case (state_q)
          S_IDLE: begin
            if (at_a && wr_byte == D_KEY1) begin
              state_d = S_U1;
            end else if (at_a && wr_byte == D_PAGE) begin
              fire    = 1'b1;
              fire_op = OP_ENTER_PAGE;
            end else if (at_a && wr_byte == D_CLEAR) begin
              fire    = 1'b1;
              fire_op = OP_CLEAR;
            end
          end
          S_U1: state_d = (at_b && wr_byte == D_KEY2) ? S_U2 : S_IDLE;
          S_U2: begin
            if (at_a && wr_byte == D_ERASE)     state_d = S_E3;
            else if (at_a && wr_byte == D_PROG) state_d = S_P3;
            else                                state_d = S_IDLE;
          end
          S_E3: state_d = (at_a && wr_byte == D_KEY1) ? S_E4 : S_IDLE;
          S_E4: state_d = (at_b && wr_byte == D_KEY2) ? S_E5 : S_IDLE;
          S_E5: begin
            state_d = S_IDLE;
            if (wr_byte == D_SEC_LOG) begin
              fire    = 1'b1;
              fire_op = OP_ERASE_LOG;
            end else if (wr_byte == D_SEC_PHYS) begin
              fire    = 1'b1;
              fire_op = OP_ERASE_PHYS;
            end
          end
          S_P3: begin
            state_d = S_IDLE;
            if (wr_byte == D_KEY1) begin
              fire    = 1'b1;
              fire_op = OP_PROGRAM;
            end
          end
          default: state_d = S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      req_valid <= 1'b0;
      req_op    <= OP_NONE;
      req_addr  <= '0;
    end else begin
      state_q   <= state_d;
      req_valid <= fire;
      if (fire) begin
        req_op   <= fire_op;
        req_addr <= wr_addr;
      end
    end
  end

  assert_hold_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hold) |=> !req_valid);

  assert_erase_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == OP_ERASE_LOG || req_op == OP_ERASE_PHYS))
      |-> $past(state_q) == S_E5);

  assert_prog_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == OP_PROGRAM) |-> $past(state_q) == S_P3);

  assert_load_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hold && at_load) |=> $stable(state_q));

endmodule

// File: rtl/fcsd_page_buf.sv
module fcsd_page_buf #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 64,
  parameter int PTR_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_ptr,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [PTR_W-1:0]  ptr,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] mem [WORDS];
  logic [PTR_W-1:0]  ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (clr_ptr) begin
      ptr_d = '0;
    end else if (load) begin
      ptr_d = (ptr_q == PTR_W'(WORDS - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  always_ff @(posedge clk) begin
    if (load) mem[ptr_q] <= load_data;
  end

  assign ptr     = ptr_q;
  assign rd_word = mem[rd_idx];

  assert_ptr_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ptr |=> ptr_q == '0);

  assert_ptr_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr_ptr) |=> ptr_q != $past(ptr_q));

  assert_word_stored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> mem[$past(ptr_q)] == $past(load_data));

endmodule

// File: rtl/fcsd_busy_ctl.sv
module fcsd_busy_ctl
  import fcsd_pkg::*;
#(
  parameter int LAT_ERASE = 8,
  parameter int LAT_PROG  = 5,
  parameter int LAT_CLR   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  op_e  fire_op,
  output logic busy
);

  localparam int LAT_M1  = (LAT_ERASE > LAT_PROG) ? LAT_ERASE : LAT_PROG;
  localparam int LAT_MAX = (LAT_M1 > LAT_CLR) ? LAT_M1 : LAT_CLR;
  localparam int CNT_W   = $clog2(LAT_MAX + 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    case (fire_op)
      OP_ERASE_LOG, OP_ERASE_PHYS: load_val = CNT_W'(LAT_ERASE - 1);
      OP_PROGRAM:                  load_val = CNT_W'(LAT_PROG - 1);
      default:                     load_val = CNT_W'(LAT_CLR - 1);
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (fire && op_takes_time(fire_op)) begin
      busy_d = 1'b1;
      cnt_d  = load_val;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

  assert_busy_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ($past(fire) && op_takes_time($past(fire_op))));

  assert_busy_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(cnt_q) == '0);

endmodule

// File: rtl/flash_cmd_seq_dec.sv
module flash_cmd_seq_dec
  import fcsd_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int PAGE_BYTES = 256,
  parameter int LAT_ERASE  = 8,
  parameter int LAT_PROG   = 5,
  parameter int LAT_CLR    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [$clog2(PAGE_BYTES/(DATA_W/8))-1:0] rd_idx,
  output logic              req_valid,
  output logic [2:0]        req_op,
  output logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic [$clog2(PAGE_BYTES/(DATA_W/8))-1:0] page_ptr,
  output logic [DATA_W-1:0] rd_word
);

  localparam int WORDS = PAGE_BYTES / (DATA_W / 8);
  localparam int PTR_W = $clog2(WORDS);

  logic fire;
  op_e  fire_op;
  op_e  req_op_e;
  logic busy_w;

  fcsd_seq_match #(.ADDR_W(ADDR_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_byte   (wr_data[7:0]),
    .hold      (busy_w),
    .fire      (fire),
    .fire_op   (fire_op),
    .req_valid (req_valid),
    .req_op    (req_op_e),
    .req_addr  (req_addr)
  );

  fcsd_page_buf #(.DATA_W(DATA_W), .WORDS(WORDS), .PTR_W(PTR_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_ptr   (fire && fire_op == OP_ENTER_PAGE),
    .load      (fire && fire_op == OP_LOAD_WORD),
    .load_data (wr_data),
    .rd_idx    (rd_idx),
    .ptr       (page_ptr),
    .rd_word   (rd_word)
  );

  fcsd_busy_ctl #(.LAT_ERASE(LAT_ERASE), .LAT_PROG(LAT_PROG), .LAT_CLR(LAT_CLR)) u_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .fire_op (fire_op),
    .busy    (busy_w)
  );

  assign busy   = busy_w;
  assign req_op = req_op_e;

  assert_load_no_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op_e == OP_LOAD_WORD) |-> !busy_w);

  assert_timed_req_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && op_takes_time(req_op_e)) |-> busy_w);

endmodule

// File: tb/flash_cmd_seq_dec_tb_top.sv
module flash_cmd_seq_dec_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  rd_idx = '0;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [15:0] req_addr;
  logic        busy;
  logic [5:0]  page_ptr;
  logic [31:0] rd_word;

  int n_chk = 0;
  int n_fail = 0;
  logic        s_valid, s_busy, any_req;
  logic [2:0]  s_op;
  logic [15:0] s_addr;
  logic [31:0] exp_mem [64];
  int exp_ptr = 0;

  always #5 clk = ~clk;

  flash_cmd_seq_dec dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_idx(rd_idx), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .busy(busy), .page_ptr(page_ptr), .rd_word(rd_word)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    s_valid = req_valid; s_op = req_op; s_addr = req_addr; s_busy = busy;
    wr_en = 1'b0;
    if (req_valid) any_req = 1'b1;
  endtask

  task automatic busy_len(input string tag, input int exp);
    int n;
    n = s_busy ? 1 : 0;
    if (s_busy) begin
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        if (!busy) break;
        n++;
      end
    end
    chk(n == exp, tag, n, exp);
  endtask

  task automatic unlock5;
    wr(16'h5554, 32'hAA); wr(16'hAAA8, 32'h55); wr(16'h5554, 32'h80);
    wr(16'h5554, 32'hAA); wr(16'hAAA8, 32'h55);
  endtask

  task automatic load(input logic [31:0] d);
    wr(16'h55F0, d);
    chk(s_valid && s_op == 3'd4 && !s_busy, "R7 load request", {s_valid, s_busy, s_op}, {1'b1, 1'b0, 3'd4});
    exp_mem[exp_ptr] = d;
    exp_ptr = (exp_ptr + 1) % 64;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] a;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!req_valid && !busy && page_ptr == 0, "R1 reset", {req_valid, busy, page_ptr}, 0);

    // R2 erase logical sector sweep
    for (int i = 0; i < 4; i++) begin
      a = 16'h0200 + 16'(i) * 16'h1000;
      any_req = 1'b0;
      unlock5;
      chk(!any_req, "R2 no early request", any_req, 0);
      wr(a, 32'hFFFF_FF30);
      chk(s_valid && s_op == 3'd1 && s_addr == a, "R2 erase logical", {s_valid, s_op, s_addr}, {1'b1, 3'd1, a});
      busy_len("R10 erase busy length", 8);
    end

    // R3 erase physical sector
    for (int i = 0; i < 3; i++) begin
      a = 16'h4000 + 16'(i) * 16'h0404;
      unlock5;
      wr(a, 32'h40);
      chk(s_valid && s_op == 3'd2 && s_addr == a, "R3 erase physical", {s_valid, s_op, s_addr}, {1'b1, 3'd2, a});
      busy_len("R10 erase physical busy length", 8);
    end

    // R4 program page
    for (int i = 0; i < 3; i++) begin
      a = 16'h2000 + 16'(i) * 16'h0100;
      wr(16'h5554, 32'hAA); wr(16'hAAA8, 32'h55); wr(16'h5554, 32'hA0);
      wr(a, 32'hAA);
      chk(s_valid && s_op == 3'd5 && s_addr == a, "R4 program page", {s_valid, s_op, s_addr}, {1'b1, 3'd5, a});
      busy_len("R10 program busy length", 5);
    end

    // R6 clear status
    wr(16'h5554, 32'hF5);
    chk(s_valid && s_op == 3'd6, "R6 clear status", {s_valid, s_op}, {1'b1, 3'd6});
    busy_len("R10 clear busy length", 2);

    // R5 enter page
    wr(16'h5554, 32'h50);
    chk(s_valid && s_op == 3'd3 && !s_busy, "R5 enter page", {s_valid, s_busy, s_op}, {1'b1, 1'b0, 3'd3});
    chk(page_ptr == 0, "R5 pointer reset", page_ptr, 0);
    exp_ptr = 0;

    // R7 fill 70 words, wrap
    for (int i = 0; i < 70; i++) load(32'hA500_0000 ^ (32'(i) * 32'h0101_0101));
    chk(page_ptr == 6'(exp_ptr), "R7 pointer wrap", page_ptr, exp_ptr);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); rd_idx = 6'(i); #1;
      chk(rd_word == exp_mem[i], "R7 buffer content", rd_word, exp_mem[i]);
    end

    // R5 pointer returns to 0 after nonzero
    wr(16'h5554, 32'h50);
    chk(page_ptr == 0, "R5 pointer reset after fill", page_ptr, 0);
    exp_ptr = 0;

    // R9 break at each step of erase sequence, then complete the rest
    for (int p = 0; p < 5; p++) begin
      any_req = 1'b0;
      for (int s = 0; s < 6; s++) begin
        case (s)
          0: begin a = 16'h5554; d = 32'hAA; end
          1: begin a = 16'hAAA8; d = 32'h55; end
          2: begin a = 16'h5554; d = 32'h80; end
          3: begin a = 16'h5554; d = 32'hAA; end
          4: begin a = 16'hAAA8; d = 32'h55; end
          default: begin a = 16'h3000; d = 32'h30; end
        endcase
        if (s == p) d = 32'h00;
        wr(a, d);
      end
      chk(!any_req, "R9 broken erase sequence", any_req, 0);
    end
    any_req = 1'b0;
    wr(16'h5554, 32'hAA); wr(16'hAAA8, 32'h55); wr(16'h5554, 32'hA0);
    wr(16'h2100, 32'h00);
    chk(!any_req, "R9 broken program sequence", any_req, 0);
    unlock5;
    wr(16'h3000, 32'h30);
    chk(s_valid && s_op == 3'd1, "R9 recovery after break", s_op, 3'd1);
    busy_len("R10 erase after recovery", 8);

    // R8 load word inside a partly matched erase sequence
    wr(16'h5554, 32'hAA); wr(16'hAAA8, 32'h55);
    load(32'h1234_5678);
    wr(16'h5554, 32'h80); wr(16'h5554, 32'hAA); wr(16'hAAA8, 32'h55);
    wr(16'h5A00, 32'h40);
    chk(s_valid && s_op == 3'd2 && s_addr == 16'h5A00, "R8 sequence survives load", {s_op, s_addr}, {3'd2, 16'h5A00});
    chk(page_ptr == 6'(exp_ptr), "R8 load advanced pointer", page_ptr, exp_ptr);

    // R11 writes ignored while busy (erase still running from above)
    chk(s_busy == 1'b1, "R11 busy active", s_busy, 1);
    wr(16'h55F0, 32'hDEAD_BEEF);
    chk(!s_valid, "R11 load ignored while busy", s_valid, 0);
    wr(16'h5554, 32'h50);
    chk(!s_valid, "R11 enter page ignored while busy", s_valid, 0);
    wr(16'h5554, 32'hF5);
    chk(!s_valid, "R11 clear ignored while busy", s_valid, 0);
    for (int k = 0; k < 20 && busy; k++) @(negedge clk);
    chk(page_ptr == 6'(exp_ptr), "R11 pointer unchanged", page_ptr, exp_ptr);
    rd_idx = 6'(exp_ptr); #1;
    chk(rd_word == exp_mem[exp_ptr], "R11 buffer unchanged", rd_word, exp_mem[exp_ptr]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule